// File: doc/BRIEF.md
# Two-Phase Clock Pulse Generator

This block turns a fast reference clock into a slow machine oscillator and a pair of phase pulses for sequencing logic that runs in the reference domain. A fractional divider makes a square wave whose average frequency is exact even when the reference is not an integer multiple of it. For the 100 MHz reference and 1.5 MHz oscillator, the half-periods alternate between 33 and 34 reference cycles.

A second level lags the oscillator by a fixed number of reference cycles. It stands in for an analog delay line and is built as a shift register. By default it has 33 stages, about 330 ns at 100 MHz. Each of the two levels has a one-cycle strobe that marks its rising edge. Downstream logic uses these strobes as clock enables and never as clocks.

Top module: `tpc_two_phase_gen`

## Requirements
- R1: While `rst_n` is low, `osc_lvl`, `osc_dly_lvl`, `ph1_stb` and `ph2_stb` are all 0. The reset acts at once, without waiting for a clock edge.
- R2: Let n be the number of rising reference edges since `rst_n` went high, with S = 2*OSC_KHZ and M = REF_KHZ. After edge n, `osc_lvl` equals floor(n*S/M) mod 2. With the defaults it first goes high after edge 34.
- R3: Every oscillator half-period, including the first one after reset, lasts either floor(M/S) or ceil(M/S) reference cycles. With the defaults that is 33 or 34.
- R4: The average frequency is exact. With the defaults, the 18th level change of `osc_lvl` comes after edge 600, so 9 full periods fit in 600 reference cycles.
- R5: After edge n, `osc_dly_lvl` equals the value `osc_lvl` had after edge n-DELAY_STAGES, and 0 when n < DELAY_STAGES. Both of its edges follow the oscillator's edges by exactly DELAY_STAGES cycles.
- R6: `ph1_stb` is 1 for exactly the one cycle after each edge where `osc_lvl` goes from 0 to 1. It is 0 at all other times.
- R7: `ph2_stb` is 1 for exactly the one cycle after each edge where `osc_dly_lvl` goes from 0 to 1. It is 0 at all other times.
- R8: A reset applied in the middle of a run clears the divider and the whole delay chain. After release, the output sequence restarts exactly as R2, R5, R6 and R7 give for n counted from the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock; all registers use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_lvl | output | 1 | Divided machine oscillator level |
| osc_dly_lvl | output | 1 | Oscillator level delayed by DELAY_STAGES cycles |
| ph1_stb | output | 1 | One-cycle strobe on the rising edge of `osc_lvl` |
| ph2_stb | output | 1 | One-cycle strobe on the rising edge of `osc_dly_lvl` |

## Verification
Every output is registered, so its result shows up in the cycle that follows edge n. The bench counts edges from the release of reset and samples on the falling clock edge. It compares the outputs after edge n with closed-form values of n: the floor expression for the oscillator, the same expression at n-DELAY_STAGES for the delayed level, and the difference between two consecutive values for each strobe. The asynchronous reset is checked one time unit after `rst_n` falls. The bench also measures each half-period length, the lag from each oscillator rise to the delayed rise, and the cycle of the 18th level change, and compares them with the fixed numbers stated in R3, R4 and R5.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

   typedef enum logic [0:0] {
      DIV_INTEGER    = 1'b0,
      DIV_FRACTIONAL = 1'b1
   } div_kind_e;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic div_kind_e pick_div(input int unsigned modulus, input int unsigned step);
      return ((modulus % step) == 0) ? DIV_INTEGER : DIV_FRACTIONAL;
   endfunction

endpackage

// File: rtl/tpc_frac_div.sv
module tpc_frac_div
   import tpc_pkg::*;
#(
   parameter int unsigned MODULUS = 100000,
   parameter int unsigned STEP    = 3000
) (
   input  logic ref_clk,
   input  logic rst_n,
   output logic lvl_q,
   output logic lvl_nxt
);

   localparam div_kind_e KIND = pick_div(MODULUS, STEP);

   logic tick;

   generate
      if (KIND == DIV_INTEGER) begin : g_int
         localparam int unsigned HALF = MODULUS / STEP;
         localparam int unsigned CW   = $clog2(HALF + 1);
         localparam logic [CW-1:0] LAST = CW'(HALF - 1);
         logic [CW-1:0] cnt_q;

         assign tick = (cnt_q == LAST);

         always_ff @(posedge ref_clk or negedge rst_n) begin
            if (!rst_n)    cnt_q <= '0;
            else if (tick) cnt_q <= '0;
            else           cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_frac
         localparam int unsigned AW = $clog2(MODULUS + STEP + 1);
         localparam logic [AW-1:0] STEP_C = AW'(STEP);
         localparam logic [AW-1:0] MOD_C  = AW'(MODULUS);
         logic [AW-1:0] acc_q;
         logic [AW-1:0] sum;

         assign sum  = acc_q + STEP_C;
         assign tick = (sum >= MOD_C);

         always_ff @(posedge ref_clk or negedge rst_n) begin
            if (!rst_n)    acc_q <= '0;
            else if (tick) acc_q <= sum - MOD_C;
            else           acc_q <= sum;
         end
      end
   endgenerate

   assign lvl_nxt = lvl_q ^ tick;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_nxt;
   end

endmodule

// File: rtl/tpc_delay_line.sv
module tpc_delay_line #(
   parameter int unsigned STAGES = 33
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic din,
   output logic pre_tap,
   output logic tap_out
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge ref_clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= din;
         end
         assign pre_tap = din;
      end else begin : g_multi
         always_ff @(posedge ref_clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], din};
         end
         assign pre_tap = chain_q[STAGES-2];
      end
   endgenerate

   assign tap_out = chain_q[STAGES-1];

endmodule

// File: rtl/tpc_rise_strobe.sv
module tpc_rise_strobe (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic lvl_now,
   input  logic lvl_next,
   output logic stb_q
);

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) stb_q <= 1'b0;
      else        stb_q <= lvl_next & ~lvl_now;
   end

endmodule

// File: rtl/tpc_two_phase_gen.sv
module tpc_two_phase_gen
   import tpc_pkg::*;
#(
   parameter int unsigned REF_KHZ      = 100000,
   parameter int unsigned OSC_KHZ      = 1500,
   parameter int unsigned DELAY_STAGES = 33
) (
   input  logic ref_clk,
   input  logic rst_n,
   output logic osc_lvl,
   output logic osc_dly_lvl,
   output logic ph1_stb,
   output logic ph2_stb
);

   localparam int unsigned STEP = 2 * OSC_KHZ;

   generate
      if (OSC_KHZ == 0) begin : g_bad_osc
         $error("OSC_KHZ must be nonzero");
      end
      if (2 * STEP > REF_KHZ) begin : g_bad_ratio
         $error("oscillator half-period must span at least two reference cycles");
      end
      if (DELAY_STAGES < 1) begin : g_bad_delay
         $error("DELAY_STAGES must be at least one");
      end
   endgenerate

   logic osc_nxt;
   logic dly_pre;

   tpc_frac_div #(.MODULUS(REF_KHZ), .STEP(STEP)) u_div (
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .lvl_q   (osc_lvl),
      .lvl_nxt (osc_nxt)
   );

   tpc_delay_line #(.STAGES(DELAY_STAGES)) u_dly (
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .din     (osc_lvl),
      .pre_tap (dly_pre),
      .tap_out (osc_dly_lvl)
   );

   tpc_rise_strobe u_ph1 (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .lvl_now  (osc_lvl),
      .lvl_next (osc_nxt),
      .stb_q    (ph1_stb)
   );

   tpc_rise_strobe u_ph2 (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .lvl_now  (osc_dly_lvl),
      .lvl_next (dly_pre),
      .stb_q    (ph2_stb)
   );

endmodule

// File: rtl/tpc_two_phase_chk.sv
module tpc_two_phase_chk
   import tpc_pkg::*;
#(
   parameter int unsigned REF_KHZ      = 100000,
   parameter int unsigned OSC_KHZ      = 1500,
   parameter int unsigned DELAY_STAGES = 33
) (
   input logic ref_clk,
   input logic rst_n,
   input logic osc_lvl,
   input logic osc_dly_lvl,
   input logic ph1_stb,
   input logic ph2_stb
);

   localparam int unsigned STEP  = 2 * OSC_KHZ;
   localparam int unsigned LO    = REF_KHZ / STEP;
   localparam int unsigned HI    = ceil_div(REF_KHZ, STEP);
   localparam int unsigned RUN_W = $clog2(HI + 2);
   localparam int unsigned LAG_W = $clog2(DELAY_STAGES + 2);

   logic             osc_prev, dly_prev;
   logic [RUN_W-1:0] run_len;
   logic [LAG_W-1:0] since_rise;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         osc_prev   <= 1'b0;
         dly_prev   <= 1'b0;
         run_len    <= '0;
         since_rise <= '0;
      end else begin
         osc_prev <= osc_lvl;
         dly_prev <= osc_dly_lvl;
         if (osc_lvl != osc_prev)            run_len <= RUN_W'(1);
         else if (run_len != RUN_W'(HI + 1)) run_len <= run_len + 1'b1;
         if (osc_lvl && !osc_prev)                            since_rise <= LAG_W'(1);
         else if (since_rise != LAG_W'(DELAY_STAGES + 1))     since_rise <= since_rise + 1'b1;
      end
   end

   // R3: each half-period is LO or HI reference cycles long
   p_half_len_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (osc_lvl != osc_prev) |-> (run_len == RUN_W'(LO) || run_len == RUN_W'(HI)));

   // R6: phase-one strobe only right after an oscillator rise, one cycle wide
   p_ph1_on_rise_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ph1_stb |-> (osc_lvl && !osc_prev));

   p_ph1_single_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ph1_stb |=> !ph1_stb);

   // R7: phase-two strobe only right after a delayed-level rise
   p_ph2_on_rise_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ph2_stb |-> (osc_dly_lvl && !dly_prev));

   p_ph2_single_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ph2_stb |=> !ph2_stb);

   // R5: delayed rise lags the oscillator rise by DELAY_STAGES cycles
   generate
      if (DELAY_STAGES < 2 * LO) begin : g_lag
         p_dly_lag_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
            (osc_dly_lvl && !dly_prev) |-> (since_rise == LAG_W'(DELAY_STAGES)));
      end
   endgenerate

endmodule

bind tpc_two_phase_gen tpc_two_phase_chk #(
   .REF_KHZ      (REF_KHZ),
   .OSC_KHZ      (OSC_KHZ),
   .DELAY_STAGES (DELAY_STAGES)
) u_chk (
   .ref_clk     (ref_clk),
   .rst_n       (rst_n),
   .osc_lvl     (osc_lvl),
   .osc_dly_lvl (osc_dly_lvl),
   .ph1_stb     (ph1_stb),
   .ph2_stb     (ph2_stb)
);

// File: tb/tb_tpc_two_phase_gen.sv
`timescale 1ns/1ps
module tb_tpc_two_phase_gen;

   localparam longint M = 100000;
   localparam longint S = 3000;
   localparam int     D = 33;
   localparam int     WATCHDOG = 200000;

   logic ref_clk = 1'b0;
   logic rst_n   = 1'b0;
   logic osc_lvl, osc_dly_lvl, ph1_stb, ph2_stb;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 ref_clk = ~ref_clk;

   tpc_two_phase_gen dut (
      .ref_clk     (ref_clk),
      .rst_n       (rst_n),
      .osc_lvl     (osc_lvl),
      .osc_dly_lvl (osc_dly_lvl),
      .ph1_stb     (ph1_stb),
      .ph2_stb     (ph2_stb)
   );

   function automatic bit e_osc(input longint n);
      if (n <= 0) return 1'b0;
      return bit'(((n * S) / M) % 2);
   endfunction
   function automatic bit e_dly(input longint n);
      return e_osc(n - D);
   endfunction
   function automatic bit e_ph1(input longint n);
      return e_osc(n) & ~e_osc(n - 1);
   endfunction
   function automatic bit e_ph2(input longint n);
      return e_dly(n) & ~e_dly(n - 1);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // R1: all outputs cleared while reset is held
   task automatic t_reset_hold(input string req, input int cycles);
      int bad = 0;
      #1;
      check(osc_lvl === 1'b0 && osc_dly_lvl === 1'b0 && ph1_stb === 1'b0 && ph2_stb === 1'b0,
            req, "outputs right after reset assertion",
            {osc_lvl, osc_dly_lvl, ph1_stb, ph2_stb}, 0);
      for (int i = 0; i < cycles; i++) begin
         @(negedge ref_clk);
         if ({osc_lvl, osc_dly_lvl, ph1_stb, ph2_stb} !== 4'b0000) bad++;
      end
      check(bad == 0, req, "cycles with nonzero output during reset", bad, 0);
   endtask

   // R2..R8: stream after release, compared against closed forms
   task automatic t_stream(input int cycles, input string tag);
      int bad_o = 0, bad_d = 0, bad_p1 = 0, bad_p2 = 0;
      int fo = 0, fd = 0, f1 = 0, f2 = 0;
      int last_tog = 0, bad_half = 0, half_val = 0;
      int last_rise = 0, bad_lag = 0, lag_val = 0, dly_rises = 0;
      int toggles = 0, tog18_at = 0;
      logic po = 1'b0, pd = 1'b0;
      @(negedge ref_clk);
      rst_n = 1'b1;
      for (int n = 1; n <= cycles; n++) begin
         @(negedge ref_clk);
         if (osc_lvl !== e_osc(n))     begin if (bad_o == 0)  fo = n; bad_o++;  end
         if (osc_dly_lvl !== e_dly(n)) begin if (bad_d == 0)  fd = n; bad_d++;  end
         if (ph1_stb !== e_ph1(n))     begin if (bad_p1 == 0) f1 = n; bad_p1++; end
         if (ph2_stb !== e_ph2(n))     begin if (bad_p2 == 0) f2 = n; bad_p2++; end
         if (n == 33) check(osc_lvl === 1'b0, {tag, " R2"}, "osc after edge 33", osc_lvl, 0);
         if (n == 34) begin
            check(osc_lvl === 1'b1, {tag, " R2"}, "osc after edge 34", osc_lvl, 1);
            check(ph1_stb === 1'b1, {tag, " R6"}, "ph1 after edge 34", ph1_stb, 1);
         end
         if (osc_lvl !== po) begin
            toggles++;
            if (toggles == 18) tog18_at = n;
            if ((n - last_tog) != 33 && (n - last_tog) != 34) begin
               bad_half++; half_val = n - last_tog;
            end
            last_tog = n;
            if (osc_lvl === 1'b1) last_rise = n;
         end
         if (osc_dly_lvl === 1'b1 && pd === 1'b0) begin
            dly_rises++;
            if (n - last_rise != D) begin bad_lag++; lag_val = n - last_rise; end
         end
         po = osc_lvl;
         pd = osc_dly_lvl;
      end
      check(bad_o == 0,  {tag, " R2"}, $sformatf("osc mismatches (first n=%0d)", fo), bad_o, 0);
      check(bad_d == 0,  {tag, " R5"}, $sformatf("delayed mismatches (first n=%0d)", fd), bad_d, 0);
      check(bad_p1 == 0, {tag, " R6"}, $sformatf("ph1 mismatches (first n=%0d)", f1), bad_p1, 0);
      check(bad_p2 == 0, {tag, " R7"}, $sformatf("ph2 mismatches (first n=%0d)", f2), bad_p2, 0);
      check(bad_half == 0, {tag, " R3"}, "half-periods not 33/34 (last length)", half_val, 33);
      check(bad_lag == 0 && dly_rises > 0, {tag, " R5"}, "rise lag (last bad)", lag_val, D);
      if (cycles >= 600)
         check(tog18_at == 600, {tag, " R4"}, "edge of 18th level change", tog18_at, 600);
   endtask

   initial begin
      rst_n = 1'b0;
      t_reset_hold("R1", 5);
      t_stream(2000, "run1");
      @(negedge ref_clk);
      #3 rst_n = 1'b0;
      t_reset_hold("R8 R1", 4);
      t_stream(700, "R8");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge ref_clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule